// File: doc/BRIEF.md
# Mode-Configurable Sum-of-Products Logic Array

This block models a small programmable logic array with eight output macrocells. Twelve dedicated inputs and eight macrocell feedback signals form the array inputs. Every macrocell owns eight product terms, and each term is the AND of the array literals selected for it. A macrocell combines its terms into a sum that drives either a flip-flop or a combinational path, and it presents a three-state pin model made of a drive value, a drive enable and a sensed pin value.

A static configuration word sets the literal connections of every term, one disable bit per term, a role for each macrocell and one global mode. The mode decides which term, if any, acts as the output enable, and which macrocells feed their pin or register back into the array. The same array can therefore stand in for registered, complex combinational or simple combinational logic. The register path has a synchronous clear and a test preload. The configuration is meant to be held constant while the block operates.

Top module: `pld_array`

## Requirements
- R1: Config term t = m*8+k (macrocell m, term k) occupies cfg_i[t*41 +: 41]. Bit j (0..19) connects array input j true, bit 20+j connects it complemented, and bit 40 disables the term, which then reads 0. Array input j<12 is ded_i[j], and j=12+m is the feedback of macrocell m. An enabled term with no connections reads 1.
- R2: The role of macrocell m is cfg_i[2624+2m +: 2] (0 combinational, 1 registered, 2 input, 3 treated as 0). The mode is cfg_i[2641:2640] (0 registered, 1 complex, 2 or 3 simple). In registered mode a registered macrocell loads the OR of all eight terms at each clock, drives the inverse of its register on pad_out_o, and has pad_oe_o equal to oe_pin_i.
- R3: In registered mode a combinational macrocell takes term 0 as its output enable and the OR of terms 1..7 as pad_out_o.
- R4: An input-role macrocell never drives (pad_oe_o low), except a centre macrocell in simple mode. Its pad_in_i feeds the array.
- R5: In complex mode every macrocell drives the OR of terms 1..7, enabled by term 0 unless it has the input role. Macrocells 0 and 7 feed back 0. The other macrocells feed back pad_in_i.
- R6: In simple mode pad_out_o is the OR of all eight terms. Non-input macrocells always drive. Macrocells 3 and 4 always drive, whatever their role, and feed back 0. The others feed back pad_in_i.
- R7: rst_i high at a clock edge clears every register, so a registered output reads 1 after that edge.
- R8: pl_en_i high at a clock edge loads pl_data_i into the registers and takes priority over the sum. A preloaded 1 appears as 0 on a registered output.
- R9: In registered mode a registered macrocell feeds back its register value, not its pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_i | input | 1 | Synchronous active-high register clear |
| oe_pin_i | input | 1 | Shared output enable for registered macrocells |
| ded_i | input | 12 | Dedicated array inputs |
| pad_in_i | input | 8 | Sensed pin values |
| pad_out_o | output | 8 | Pin drive values |
| pad_oe_o | output | 8 | Pin drive enables |
| cfg_i | input | 2642 | Static configuration word |
| pl_en_i | input | 1 | Preload strobe |
| pl_data_i | input | 8 | Preload values |

## Verification
The hardest case to reach is feedback that the mode withholds: an outer macrocell in complex mode, or a centre macrocell in simple mode, whose pin is driven high but whose feedback must still read 0. The bench connects a neighbouring macrocell's only term to that feedback, drives the pin high, and checks that the neighbour's output stays low. It then moves the same term to a macrocell whose feedback is allowed and checks that the output rises. Register feedback is reached with a preload that sets a register opposite to its pin, so the register value and the pin value can be told apart at the neighbour's output.

// File: rtl/pld_array.sv
module pld_array #(
  parameter int NDED = 12,
  parameter int NMC  = 8,
  parameter int NPT  = 8,
  localparam int NARR  = NDED + NMC,
  localparam int TW    = 2 * NARR + 1,
  localparam int RBASE = NMC * NPT * TW,
  localparam int CFG_W = RBASE + 2 * NMC + 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             oe_pin_i,
  input  logic [NDED-1:0]  ded_i,
  input  logic [NMC-1:0]   pad_in_i,
  output logic [NMC-1:0]   pad_out_o,
  output logic [NMC-1:0]   pad_oe_o,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             pl_en_i,
  input  logic [NMC-1:0]   pl_data_i
);
  logic [NMC-1:0]     q, fb;
  logic [NARR-1:0]    arr;
  logic [NMC*NPT-1:0] pt;
  logic [1:0]         mode;

  assign arr  = {fb, ded_i};
  assign mode = cfg_i[CFG_W-2 +: 2];

  for (genvar t = 0; t < NMC*NPT; t++) begin : g_term
    logic [TW-1:0] c;
    assign c     = cfg_i[t*TW +: TW];
    assign pt[t] = ~c[2*NARR] & (&(~c[NARR-1:0] | arr)) & (&(~c[2*NARR-1:NARR] | ~arr));
  end

  for (genvar m = 0; m < NMC; m++) begin : g_mc
    localparam bit OUTER  = (m == 0) || (m == NMC - 1);
    localparam bit CENTRE = (m == NMC/2 - 1) || (m == NMC/2);
    logic [NPT-1:0] p;
    logic [1:0]     role;
    logic           s8, s7, o, e, f;

    assign p    = pt[m*NPT +: NPT];
    assign role = cfg_i[RBASE + 2*m +: 2];
    assign s8   = |p;
    assign s7   = |p[NPT-1:1];

    always_ff @(posedge clk_i) begin
      if (rst_i)        q[m] <= 1'b0;
      else if (pl_en_i) q[m] <= pl_data_i[m];
      else              q[m] <= s8;
    end

    always_comb begin
      case (mode)
        2'd0: begin
          if (role == 2'd1) begin
            o = ~q[m]; e = oe_pin_i; f = q[m];
          end else begin
            o = s7; e = (role == 2'd2) ? 1'b0 : p[0]; f = pad_in_i[m];
          end
        end
        2'd1: begin
          o = s7;
          e = (role == 2'd2) ? 1'b0 : p[0];
          f = OUTER ? 1'b0 : pad_in_i[m];
        end
        default: begin
          o = s8;
          e = CENTRE ? 1'b1 : (role != 2'd2);
          f = CENTRE ? 1'b0 : pad_in_i[m];
        end
      endcase
    end

    assign pad_out_o[m] = o;
    assign pad_oe_o[m]  = e;
    assign fb[m]        = f;
  end
endmodule

// File: rtl/pld_array_chk.sv
module pld_array_chk #(
  parameter int NDED = 12,
  parameter int NMC  = 8,
  parameter int NPT  = 8,
  localparam int NARR  = NDED + NMC,
  localparam int TW    = 2 * NARR + 1,
  localparam int RBASE = NMC * NPT * TW,
  localparam int CFG_W = RBASE + 2 * NMC + 2
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             oe_pin_i,
  input logic [NDED-1:0]  ded_i,
  input logic [NMC-1:0]   pad_in_i,
  input logic [NMC-1:0]   pad_out_o,
  input logic [NMC-1:0]   pad_oe_o,
  input logic [CFG_W-1:0] cfg_i,
  input logic             pl_en_i,
  input logic [NMC-1:0]   pl_data_i
);
  logic [1:0] mode;
  assign mode = cfg_i[CFG_W-2 +: 2];

  for (genvar m = 0; m < NMC; m++) begin : g_chk
    localparam bit CENTRE = (m == NMC/2 - 1) || (m == NMC/2);
    logic [1:0] role;
    assign role = cfg_i[RBASE + 2*m +: 2];

    assert_input_off_R4: assert property (@(posedge clk_i)
      (role == 2'd2 && !(mode[1] && CENTRE)) |-> !pad_oe_o[m]);

    if (CENTRE) begin : g_c
      assert_centre_on_R6: assert property (@(posedge clk_i)
        mode[1] |-> pad_oe_o[m]);
    end

    assert_reg_oe_R2: assert property (@(posedge clk_i)
      (mode == 2'd0 && role == 2'd1) |-> (pad_oe_o[m] == oe_pin_i));

    assert_reset_high_R7: assert property (@(posedge clk_i)
      rst_i |=> (mode != 2'd0 || role != 2'd1 || pad_out_o[m]));

    assert_preload_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      pl_en_i |=> (mode != 2'd0 || role != 2'd1 || pad_out_o[m] == !$past(pl_data_i[m])));
  end
endmodule

bind pld_array pld_array_chk #(.NDED(NDED), .NMC(NMC), .NPT(NPT)) chk_i (.*);

// File: tb/pld_array_tb_top.sv
module pld_array_tb_top;
  localparam int NDED = 12, NMC = 8, NPT = 8;
  localparam int NARR = NDED + NMC, TW = 2*NARR + 1;
  localparam int RBASE = NMC*NPT*TW, CFG_W = RBASE + 2*NMC + 2;

  logic clk = 0, rst = 1, oe_pin = 1, pl_en = 0;
  logic [NDED-1:0] ded = '0;
  logic [NMC-1:0] pad_in = '0, pl_data = '0, pad_out, pad_oe;
  logic [CFG_W-1:0] cfg = '0;
  int errs = 0, checks = 0;

  always #2 clk = ~clk;

  pld_array dut_i (.clk_i(clk), .rst_i(rst), .oe_pin_i(oe_pin), .ded_i(ded),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe), .cfg_i(cfg),
    .pl_en_i(pl_en), .pl_data_i(pl_data));

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic clear_cfg();
    cfg = '0;
    for (int t = 0; t < NMC*NPT; t++) cfg[t*TW + 2*NARR] = 1'b1;
  endtask
  task automatic en_term(int m, int k);
    cfg[(m*NPT+k)*TW + 2*NARR] = 1'b0;
  endtask
  task automatic lit(int m, int k, int j, bit comp);
    en_term(m, k);
    cfg[(m*NPT+k)*TW + (comp ? NARR : 0) + j] = 1'b1;
  endtask
  task automatic set_role(int m, int r);
    cfg[RBASE + 2*m +: 2] = 2'(r);
  endtask
  task automatic set_mode(int md);
    cfg[CFG_W-2 +: 2] = 2'(md);
  endtask
  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    clear_cfg(); set_mode(0); set_role(0, 1);
    rst = 1; oe_pin = 1;
    tick(); tick();
    chk("R7 reset output high", pad_out[0], 1'b1);
    chk("R2 oe from pin high", pad_oe[0], 1'b1);
    oe_pin = 0; #1;
    chk("R2 oe from pin low", pad_oe[0], 1'b0);
    oe_pin = 1; rst = 0;
  endtask

  task automatic t_registered();
    lit(0, 0, 0, 0); lit(0, 7, 1, 0);
    ded = '0; tick();
    chk("R2 sum 0 -> out 1", pad_out[0], 1'b1);
    ded[0] = 1; tick();
    chk("R2 term0 -> out 0", pad_out[0], 1'b0);
    ded[0] = 0; ded[1] = 1; tick();
    chk("R2 term7 -> out 0", pad_out[0], 1'b0);
    ded = '0; tick();
    chk("R2 back to 1", pad_out[0], 1'b1);
    rst = 1; ded[0] = 1; tick(); rst = 0;
    chk("R7 clear over sum", pad_out[0], 1'b1);
  endtask

  task automatic t_preload();
    ded[0] = 1; pl_en = 1; pl_data = '0; tick();
    chk("R8 preload 0 beats sum", pad_out[0], 1'b1);
    ded = '0; pl_data[0] = 1; tick();
    chk("R8 preload 1 -> out 0", pad_out[0], 1'b0);
    pl_en = 0;
    en_term(1, 0); lit(1, 1, NDED+0, 0); pad_in[0] = 0; #1;
    chk("R9 register fed back", pad_out[1], 1'b1);
    pl_en = 1; pl_data = '0; pad_in[0] = 1; tick(); pl_en = 0;
    chk("R9 pin ignored", pad_out[1], 1'b0);
    pad_in = '0;
  endtask

  task automatic t_comb_reg_mode();
    clear_cfg(); set_mode(0);
    lit(1, 0, 2, 0); lit(1, 1, 3, 0);
    ded = '0; #1;
    chk("R3 oe off", pad_oe[1], 1'b0);
    ded[2] = 1; #1;
    chk("R3 oe on", pad_oe[1], 1'b1);
    chk("R3 term0 not summed", pad_out[1], 1'b0);
    ded[3] = 1; #1;
    chk("R3 term1 summed", pad_out[1], 1'b1);
    ded = '0;
  endtask

  task automatic t_input_and_literals();
    clear_cfg(); set_mode(0);
    set_role(2, 2); en_term(2, 0);
    en_term(3, 0); lit(3, 1, NDED+2, 0);
    pad_in[2] = 1; #1;
    chk("R4 input never drives", pad_oe[2], 1'b0);
    chk("R4 pin feeds array", pad_out[3], 1'b1);
    pad_in[2] = 0; #1;
    chk("R4 pin low", pad_out[3], 1'b0);
    clear_cfg(); set_mode(0); en_term(3, 0); lit(3, 1, 5, 1);
    ded[5] = 0; #1;
    chk("R1 complement true", pad_out[3], 1'b1);
    ded[5] = 1; #1;
    chk("R1 complement false, disabled terms 0", pad_out[3], 1'b0);
    ded = '0;
  endtask

  task automatic t_complex();
    clear_cfg(); set_mode(1);
    lit(1, 0, 2, 0); lit(1, 1, NDED+0, 0);
    ded[2] = 1; pad_in[0] = 1; #1;
    chk("R5 oe term0", pad_oe[1], 1'b1);
    chk("R5 outer no feedback", pad_out[1], 1'b0);
    clear_cfg(); set_mode(1); lit(1, 0, 2, 0); lit(1, 1, NDED+6, 0);
    pad_in[6] = 1; #1;
    chk("R5 inner feedback", pad_out[1], 1'b1);
    ded[2] = 0; #1;
    chk("R5 oe off", pad_oe[1], 1'b0);
    ded = '0; pad_in = '0;
  endtask

  task automatic t_simple();
    clear_cfg(); set_mode(2);
    lit(1, 0, 0, 0); set_role(2, 2); set_role(3, 2); en_term(3, 0);
    ded[0] = 1; #1;
    chk("R6 term0 summed", pad_out[1], 1'b1);
    chk("R6 output always on", pad_oe[1], 1'b1);
    chk("R6 non-centre input off", pad_oe[2], 1'b0);
    chk("R6 centre always drives", pad_oe[3], 1'b1);
    chk("R6 centre output value", pad_out[3], 1'b1);
    clear_cfg(); set_mode(2); set_role(3, 2); lit(1, 0, NDED+3, 0);
    pad_in[3] = 1; #1;
    chk("R6 centre no feedback", pad_out[1], 1'b0);
    clear_cfg(); set_mode(2); set_role(2, 2); lit(1, 0, NDED+2, 0);
    pad_in[2] = 1; #1;
    chk("R6 non-centre feedback", pad_out[1], 1'b1);
    ded = '0; pad_in = '0;
  endtask

  initial begin
    clear_cfg();
    @(negedge clk);
    t_reset();
    t_registered();
    t_preload();
    t_comb_reg_mode();
    t_input_and_literals();
    t_complex();
    t_simple();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #200000;
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule